// File: doc/BRIEF.md
# Transmit Inter-Packet Gap Controller

This block decides how many idle octets follow each frame on a 10-gigabit transmit path that moves four byte lanes per clock, and holds the frame source off for the idle words that this takes. The source presents one data word per cycle with `frm_active`. It marks the final word with `frm_eof` and gives the number of valid bytes in that word. The block answers with a one-cycle `gap_valid` strobe that carries the idle-octet count. It then raises `tx_hold` for as many whole idle words as the gap needs, so that the next frame starts in lane 0.

One programmed gap field means two different things. In LAN mode it is an octet count. The block applies it with deficit idle counting: it removes idles from some gaps and adds them to others, so the next start of frame stays on lane 0 while the average gap stays at the programmed value. In WAN mode the field is a stretch setting. For every (setting+1) octets sent, one extra idle octet is owed. The owed octets are added to a 12-octet minimum gap, and the total is rounded up to a lane boundary. This slows the average data rate to match a slower payload rate, and a larger setting gives a shorter gap. The reset value of the field is 12, which gives a standard gap in either mode. Encoding the idle control characters is done further down the path.

Top module: `tx_gap_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `tx_hold`, `gap_valid` and `gap_octets` are all zero until the first end-of-frame word is accepted.
- R2: In LAN mode only bits 5:0 of `gap_field` count, and bits 9:6 are ignored. The effective gap is that 6-bit value rounded to the nearest multiple of 4, with a remainder of 2 rounding up. The result is never less than 8.
- R3: `gap_floor_warn` is 1 exactly when LAN mode is selected and the effective LAN gap is 8. It is 0 in WAN mode.
- R4: LAN deficit rule. Let b be the number of bytes in the last word and p = (4-b) mod 4. If p = 0, the gap equals the effective gap G. Otherwise, if deficit + (4-p) <= 3, the gap is G-(4-p) and the deficit grows by 4-p. Otherwise the gap is G+p and the deficit shrinks by p. The deficit starts at 0, stays within 0 to 3, and changes only on LAN end-of-frame words.
- R5: In both modes, b + `gap_octets` is a multiple of 4, so the next frame starts in lane 0.
- R6: In WAN mode bits 5:0 of `gap_field` are clamped to 4..15, giving the setting s. Each accepted WAN word adds its bytes to a residue. When the residue reaches s+1, s+1 is subtracted once and one extra octet is owed. The residue carries over from frame to frame. The owed count clears after each WAN end-of-frame word.
- R7: The WAN gap is the smallest value not less than 12 plus the owed octets (including any octet owed because of the final word) that makes b + gap a multiple of 4.
- R8: `gap_valid` is high for exactly the one cycle after the cycle in which the end-of-frame word is accepted. `gap_octets` changes in that cycle and keeps its value until the next end-of-frame word.
- R9: `tx_hold` is high for (`gap_octets` - p)/4 cycles, starting in the cycle after the end-of-frame word. Words presented while `tx_hold` is high are ignored, including end-of-frame words.
- R10: `eof_bytes` value k means the last word holds k+1 bytes, filled from lane 0. Every word that is not the last carries 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_active | input | 1 | A frame data word is presented this cycle |
| frm_eof | input | 1 | The presented word is the last word of its frame |
| eof_bytes | input | 2 | Valid bytes in the last word, minus one |
| wan_mode | input | 1 | 0 selects LAN gap rules, 1 selects WAN stretch |
| gap_field | input | 10 | Programmed gap field; bits 5:0 are used |
| tx_hold | output | 1 | Source must not present words |
| gap_valid | output | 1 | One-cycle strobe for a new gap value |
| gap_octets | output | 16 | Idle octets after the last data byte |
| gap_floor_warn | output | 1 | LAN gap is at the 8-octet floor |

## Verification
Two functions can fall in the same cycle. The first is the end-of-frame word that completes a WAN residue wrap. The final word's bytes can push the residue past s+1, and the octet owed for that wrap has to show up in the gap reported for that same frame, not in the next one. Random frame lengths and settings produce many frames whose final word causes a wrap, and every gap is compared with a reference that processes the words in order. The second case is an end-of-frame word offered in the first hold cycle. It must neither restart the hold count nor produce a second strobe.

// File: rtl/tx_gap_pkg.sv
package tx_gap_pkg;
  localparam int LANE_BYTES = 4;
  localparam int LANE_W     = 2;
  localparam int BYTE_CNT_W = 3;
  typedef enum logic {
    MODE_LAN = 1'b0,
    MODE_WAN = 1'b1
  } gap_mode_e;
endpackage

// File: rtl/tx_gap_cfg_decode.sv
module tx_gap_cfg_decode #(
  parameter int CFG_W   = 10,
  parameter int USE_W   = 6,
  parameter int GAP_W   = 8,
  parameter int DIV_W   = 5,
  parameter int LAN_MIN = 8,
  parameter int WAN_MIN = 4,
  parameter int WAN_MAX = 15
) (
  input  logic [CFG_W-1:0] gap_field,
  output logic [GAP_W-1:0] lan_gap,
  output logic [DIV_W-1:0] wan_div,
  output logic             lan_at_floor
);
  localparam logic [GAP_W-1:0] LAN_FLOOR = GAP_W'(LAN_MIN);
  logic [USE_W-1:0] used;
  logic [GAP_W-1:0] rounded;

  always_comb begin
    used    = gap_field[USE_W-1:0];
    rounded = (GAP_W'(used) + GAP_W'(2)) & ~GAP_W'(3);
    lan_gap = (rounded < LAN_FLOOR) ? LAN_FLOOR : rounded;
    if (used < USE_W'(WAN_MIN))      wan_div = DIV_W'(WAN_MIN + 1);
    else if (used > USE_W'(WAN_MAX)) wan_div = DIV_W'(WAN_MAX + 1);
    else                             wan_div = DIV_W'(used) + DIV_W'(1);
    lan_at_floor = (lan_gap == LAN_FLOOR);
  end
endmodule

// File: rtl/tx_gap_lan_dic.sv
module tx_gap_lan_dic #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [2:0]       last_bytes,
  input  logic [GAP_W-1:0] lan_gap,
  output logic [GAP_W-1:0] lan_octets
);
  logic [1:0] deficit_q;
  logic [2:0] deficit_n;
  logic [1:0] pad;
  logic [2:0] shrink;
  logic [2:0] trial;

  always_comb begin
    pad    = 2'(3'd4 - last_bytes);
    shrink = 3'd4 - {1'b0, pad};
    trial  = {1'b0, deficit_q} + shrink;
    if (pad == 2'd0) begin
      lan_octets = lan_gap;
      deficit_n  = {1'b0, deficit_q};
    end else if (trial <= 3'd3) begin
      lan_octets = lan_gap - GAP_W'(shrink);
      deficit_n  = trial;
    end else begin
      lan_octets = lan_gap + GAP_W'(pad);
      deficit_n  = {1'b0, deficit_q} - {1'b0, pad};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      deficit_q <= 2'd0;
    else if (upd_en) deficit_q <= deficit_n[1:0];
  end

  assert_deficit_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (deficit_n <= 3'd3));
  assert_lan_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ((lan_octets + GAP_W'(3) >= lan_gap) && (lan_octets <= lan_gap + GAP_W'(3))));
endmodule

// File: rtl/tx_gap_wan_stretch.sv
module tx_gap_wan_stretch #(
  parameter int DIV_W   = 5,
  parameter int EXTRA_W = 12,
  parameter int OCT_W   = 16,
  parameter int MIN_GAP = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_en,
  input  logic             eof,
  input  logic [2:0]       word_bytes,
  input  logic [DIV_W-1:0] wan_div,
  output logic [OCT_W-1:0] wan_octets
);
  logic [DIV_W-1:0]   resid_q, resid_n;
  logic [EXTRA_W-1:0] extra_q, extra_n;
  logic [DIV_W:0]     sum;
  logic               wrap;
  logic [OCT_W-1:0]   need, aligned;

  always_comb begin
    sum        = {1'b0, resid_q} + (DIV_W+1)'(word_bytes);
    wrap       = (sum >= {1'b0, wan_div});
    resid_n    = wrap ? DIV_W'(sum - {1'b0, wan_div}) : DIV_W'(sum);
    extra_n    = extra_q + EXTRA_W'(wrap);
    need       = OCT_W'(MIN_GAP) + OCT_W'(extra_n) + OCT_W'(word_bytes);
    aligned    = (need + OCT_W'(3)) & ~OCT_W'(3);
    wan_octets = aligned - OCT_W'(word_bytes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resid_q <= '0;
      extra_q <= '0;
    end else if (word_en) begin
      resid_q <= resid_n;
      extra_q <= eof ? '0 : extra_n;
    end
  end

  assert_wan_min_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_en && eof) |-> (wan_octets >= OCT_W'(MIN_GAP)));
endmodule

// File: rtl/tx_gap_hold_timer.sv
module tx_gap_hold_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_words,
  output logic             hold
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)                 cnt_n = load_words;
    else if (cnt_q != '0)     cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign hold = (cnt_q != '0);

  assert_hold_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_words != '0)) |=> hold);
endmodule

// File: rtl/tx_gap_ctrl.sv
module tx_gap_ctrl #(
  parameter int CFG_W       = 10,
  parameter int USE_W       = 6,
  parameter int OCT_W       = 16,
  parameter int EXTRA_W     = 12,
  parameter int WAN_MIN_GAP = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_active,
  input  logic             frm_eof,
  input  logic [1:0]       eof_bytes,
  input  logic             wan_mode,
  input  logic [CFG_W-1:0] gap_field,
  output logic             tx_hold,
  output logic             gap_valid,
  output logic [OCT_W-1:0] gap_octets,
  output logic             gap_floor_warn
);
  import tx_gap_pkg::*;
  localparam int GAP_W = 8;
  localparam int DIV_W = 5;
  localparam int CNT_W = OCT_W - LANE_W;

  logic             word_take, eof_fire;
  logic [2:0]       word_bytes;
  logic [1:0]       pad;
  logic [GAP_W-1:0] lan_gap, lan_octets;
  logic [DIV_W-1:0] wan_div;
  logic             lan_at_floor;
  logic [OCT_W-1:0] wan_octets, sel_octets;
  logic [CNT_W-1:0] hold_words;
  gap_mode_e        mode;
  logic             valid_q;
  logic [OCT_W-1:0] octets_q, octets_n;
  logic [2:0]       lastb_q, lastb_n;

  always_comb begin
    mode       = gap_mode_e'(wan_mode);
    word_take  = frm_active & ~tx_hold;
    eof_fire   = word_take & frm_eof;
    word_bytes = frm_eof ? ({1'b0, eof_bytes} + 3'd1) : 3'(LANE_BYTES);
    pad        = 2'(3'd4 - word_bytes);
    sel_octets = (mode == MODE_WAN) ? wan_octets : OCT_W'(lan_octets);
    hold_words = CNT_W'((sel_octets - OCT_W'(pad)) >> LANE_W);
    octets_n   = eof_fire ? sel_octets : octets_q;
    lastb_n    = eof_fire ? word_bytes : lastb_q;
  end

  tx_gap_cfg_decode #(.CFG_W(CFG_W), .USE_W(USE_W), .GAP_W(GAP_W), .DIV_W(DIV_W)) u_dec (
    .gap_field(gap_field), .lan_gap(lan_gap), .wan_div(wan_div), .lan_at_floor(lan_at_floor));

  tx_gap_lan_dic #(.GAP_W(GAP_W)) u_lan (
    .clk(clk), .rst_n(rst_n), .upd_en(eof_fire && (mode == MODE_LAN)),
    .last_bytes(word_bytes), .lan_gap(lan_gap), .lan_octets(lan_octets));

  tx_gap_wan_stretch #(.DIV_W(DIV_W), .EXTRA_W(EXTRA_W), .OCT_W(OCT_W), .MIN_GAP(WAN_MIN_GAP)) u_wan (
    .clk(clk), .rst_n(rst_n), .word_en(word_take && (mode == MODE_WAN)), .eof(frm_eof),
    .word_bytes(word_bytes), .wan_div(wan_div), .wan_octets(wan_octets));

  tx_gap_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(eof_fire), .load_words(hold_words), .hold(tx_hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      octets_q <= '0;
      lastb_q  <= 3'd4;
    end else begin
      valid_q  <= eof_fire;
      octets_q <= octets_n;
      lastb_q  <= lastb_n;
    end
  end

  assign gap_valid      = valid_q;
  assign gap_octets     = octets_q;
  assign gap_floor_warn = (mode == MODE_LAN) & lan_at_floor;

  assert_lane_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_valid |-> (((gap_octets + OCT_W'(lastb_q)) & OCT_W'(3)) == '0));
  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_valid |=> !gap_valid);
  assert_hold_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_valid |-> tx_hold);
endmodule

// File: tb/tx_gap_ctrl_test.sv
module tx_gap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_active, frm_eof, wan_mode;
  logic [1:0]  eof_bytes;
  logic [9:0]  gap_field;
  logic        tx_hold, gap_valid, gap_floor_warn;
  logic [15:0] gap_octets;

  int checks = 0;
  int errors = 0;
  int deficit = 0;
  int resid = 0;
  int owed = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tx_gap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frm_active(frm_active), .frm_eof(frm_eof),
    .eof_bytes(eof_bytes), .wan_mode(wan_mode), .gap_field(gap_field),
    .tx_hold(tx_hold), .gap_valid(gap_valid), .gap_octets(gap_octets),
    .gap_floor_warn(gap_floor_warn));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lan_eff(input int field);
    int v;
    int r;
    v = field % 64;
    r = ((v + 2) / 4) * 4;
    if (r < 8) r = 8;
    return r;
  endfunction

  function automatic int wan_set(input int field);
    int v;
    v = field % 64;
    if (v < 4) v = 4;
    if (v > 15) v = 15;
    return v;
  endfunction

  task automatic send_frame(input string tag, input int len, input bit wan, input int field, input bit poke);
    int words, b, p, t, h, n, g, dv, need;
    words = (len + 3) / 4;
    b = len - 4 * (words - 1);
    p = (4 - b) % 4;
    if (wan) begin
      dv = wan_set(field) + 1;
      for (int w = 0; w < words; w++) begin
        resid += (w == words - 1) ? b : 4;
        if (resid >= dv) begin resid -= dv; owed++; end
      end
      need = 12 + owed + b;
      t = ((need + 3) / 4) * 4 - b;
      owed = 0;
    end else begin
      g = lan_eff(field);
      if (p == 0) t = g;
      else if (deficit + (4 - p) <= 3) begin t = g - (4 - p); deficit += 4 - p; end
      else begin t = g + p; deficit -= p; end
    end
    h = (t - p) / 4;
    gap_field = field[9:0];
    wan_mode  = wan;
    #1;
    chk("R3 warn", gap_floor_warn, (!wan && lan_eff(field) == 8) ? 1 : 0);
    for (int w = 0; w < words; w++) begin
      frm_active = 1'b1;
      frm_eof    = (w == words - 1);
      eof_bytes  = (w == words - 1) ? 2'(b - 1) : 2'd0;
      @(negedge clk);
    end
    frm_active = 1'b0;
    frm_eof    = 1'b0;
    chk("R8 strobe", gap_valid, 1);
    chk(tag, gap_octets, t);
    chk("R5 align", (b + gap_octets) % 4, 0);
    if (poke) begin
      frm_active = 1'b1;
      frm_eof    = 1'b1;
      eof_bytes  = 2'($urandom % 4);
    end
    n = 0;
    while (tx_hold && n < 70000) begin
      n++;
      @(negedge clk);
      if (n == 1) begin
        frm_active = 1'b0;
        frm_eof    = 1'b0;
        chk(poke ? "R9 ignored word" : "R8 pulse width", gap_valid, 0);
      end
    end
    chk("R9 hold length", n, h);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected below 150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0;
    frm_active = 1'b0;
    frm_eof = 1'b0;
    eof_bytes = 2'd0;
    wan_mode = 1'b0;
    gap_field = 10'd12;
    repeat (3) @(negedge clk);
    chk("R1 hold in reset", tx_hold, 0);
    chk("R1 strobe in reset", gap_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 octets after reset", gap_octets, 0);
    chk("R1 hold after reset", tx_hold, 0);

    send_frame("R4 default gap", 64, 1'b0, 12, 1'b0);
    send_frame("R4 deficit grow", 65, 1'b0, 12, 1'b0);
    send_frame("R4 deficit grow", 66, 1'b0, 12, 1'b0);
    send_frame("R4 deficit insert", 67, 1'b0, 12, 1'b0);
    send_frame("R2 floor", 40, 1'b0, 0, 1'b0);
    send_frame("R2 exact floor", 41, 1'b0, 8, 1'b0);
    send_frame("R2 tie rounds up", 42, 1'b0, 10, 1'b0);
    send_frame("R2 upper bits ignored", 43, 1'b0, 10'h3CE, 1'b0);
    send_frame("R2 top value", 44, 1'b0, 63, 1'b0);
    send_frame("R10 single byte", 1, 1'b0, 12, 1'b0);
    send_frame("R7 wan default", 64, 1'b1, 12, 1'b0);
    send_frame("R6 wan low clamp", 100, 1'b1, 0, 1'b0);
    send_frame("R6 wan high clamp", 100, 1'b1, 63, 1'b0);
    send_frame("R7 wan final-word wrap", 5, 1'b1, 4, 1'b1);
    send_frame("R9 poke lan", 30, 1'b0, 20, 1'b1);

    for (int i = 0; i < 200; i++) begin
      bit w;
      w = 1'($urandom % 2);
      send_frame(w ? "R7 random wan" : "R4 random lan", 1 + ($urandom % 200), w,
                 int'($urandom % 1024), ($urandom % 4) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule